// File: doc/BRIEF.md
# Fully Associative Translation Cache with Least-Recently-Used Replacement

This block keeps a small set of recent virtual-page to physical-page translations in front of a page table walker. Every stored entry is compared against the incoming virtual page number in the same cycle. A hit returns the physical page number and a protection-fault flag, combinationally. The flag is raised when the stored read, write and execute bits do not allow the requested kind of access.

On a miss, the surrounding logic walks the page table and hands the result back through the fill port, so the translation is installed for later lookups. A fill goes to an empty slot when one exists. When the array is full, it replaces the entry that was used least recently, where both hits and fills count as use. A flush input empties the whole array in one clock edge, for example when the address space changes.

Top module: `xlat_cache`

## Requirements
- R1: `hit` is high in the same cycle that `lookupValid` is high and a valid entry holds `lookupVpn`. `hit` is low whenever `lookupValid` is low.
- R2: On a hit, `hitPpn` carries the physical page number stored with the matching entry. On a miss, `hitPpn` is zero.
- R3: `lookupAcc` encodes the access: 0 is read, 1 is write, 2 is execute, and 3 is reserved. The permission bits are `fillPerm[0]` for read, `[1]` for write and `[2]` for execute. On a hit, `permFault` is high when the bit for the access is clear, and it is always high for code 3. On a miss, `permFault` is low.
- R4: A fill of a new page number uses an empty entry while one exists. Filling as many distinct pages as there are entries, starting from empty, therefore loses none of them.
- R5: A fill whose page number is already present overwrites that entry's physical page and permissions in place. No duplicate is created and no other entry is lost.
- R6: When all entries are valid, a fill of a new page number replaces the entry whose last hit or fill lies furthest in the past.
- R7: A flush invalidates every entry at one clock edge. Every lookup afterwards misses until new fills arrive.
- R8: A fill presented in the same cycle as a flush is dropped.
- R9: After reset, every entry is invalid.
- R10: A lookup in the same cycle as a fill sees the contents from before the fill. For replacement age, the filled entry counts as the most recent use, and that cycle's lookup hit does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lookupValid | input | 1 | Lookup request this cycle |
| lookupVpn | input | VPN_W | Virtual page number to translate |
| lookupAcc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| fillValid | input | 1 | Install a translation from the walker |
| fillVpn | input | VPN_W | Virtual page number of the fill |
| fillPpn | input | PPN_W | Physical page number of the fill |
| fillPerm | input | 3 | Permissions: bit0 read, bit1 write, bit2 execute |
| flush | input | 1 | Invalidate all entries |
| hit | output | 1 | Lookup matched a valid entry |
| hitPpn | output | PPN_W | Translated physical page number, zero on miss |
| permFault | output | 1 | Hit whose permissions forbid the access |

## Verification
The bench builds the block with 8 entries and 20-bit page numbers. With that size, a few lookups put the array in a chosen recency order, and the replacement victim can be predicted and confirmed after a single extra fill. A random phase draws from only 16 page numbers, so the array is filled, overflowed, overwritten in place and flushed many times. This exercises eviction under many recency orders, along with the cases where a fill and a lookup, or a fill and a flush, arrive in the same cycle.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  // Widest entry index the strobe struct can carry (up to 256 entries)
  localparam int IDX_MAX = 8;

  // Access kinds on the lookup port
  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_RSVD  = 2'd3
  } accKind_e;

  // Strobes from control to the entry store
  typedef struct packed {
    logic               flushAll;
    logic               wrEn;
    logic [IDX_MAX-1:0] wrIdx;
  } storeStrobe_t;

endpackage

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IdxW   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  storeStrobe_t      strobe,
  input  logic              lookupValid,
  input  logic [VPN_W-1:0]  lookupVpn,
  input  logic [1:0]        lookupAcc,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PPN_W-1:0]  fillPpn,
  input  logic [2:0]        fillPerm,
  output logic              hit,
  output logic [PPN_W-1:0]  hitPpn,
  output logic              permFault,
  output logic [IdxW-1:0]   hitIdx,
  output logic [ENTRIES-1:0] validVec,
  output logic              fillMatch,
  output logic [IdxW-1:0]   fillMatchIdx
);

  logic [ENTRIES-1:0] lookVec;
  logic [ENTRIES-1:0] fillVec;
  logic [PPN_W-1:0]   ppnArr  [ENTRIES];
  logic [2:0]         permArr [ENTRIES];

  // One storage slot and two comparators per entry
  for (genvar i = 0; i < ENTRIES; i++) begin : gEnt
    logic             entValid;
    logic [VPN_W-1:0] entVpn;
    logic [PPN_W-1:0] entPpn;
    logic [2:0]       entPerm;
    logic             selMe;

    assign selMe = strobe.wrEn && (strobe.wrIdx == IDX_MAX'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                entValid <= 1'b0;
      else if (strobe.flushAll) entValid <= 1'b0;
      else if (selMe)           entValid <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (selMe && !strobe.flushAll) begin
        entVpn  <= fillVpn;
        entPpn  <= fillPpn;
        entPerm <= fillPerm;
      end
    end

    assign validVec[i] = entValid;
    assign lookVec[i]  = lookupValid && entValid && (entVpn == lookupVpn);
    assign fillVec[i]  = entValid && (entVpn == fillVpn);
    assign ppnArr[i]   = entPpn;
    assign permArr[i]  = entPerm;
  end

  // At most one entry matches, because fills never duplicate a page number
  logic [2:0] selPerm;
  always_comb begin
    hitIdx       = '0;
    fillMatchIdx = '0;
    hitPpn       = '0;
    selPerm      = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lookVec[i]) begin
        hitIdx  = IdxW'(i);
        hitPpn  = hitPpn | ppnArr[i];
        selPerm = selPerm | permArr[i];
      end
      if (fillVec[i]) fillMatchIdx = IdxW'(i);
    end
  end

  assign hit       = |lookVec;
  assign fillMatch = |fillVec;

  always_comb begin
    unique case (accKind_e'(lookupAcc))
      ACC_READ:  permFault = hit && !selPerm[0];
      ACC_WRITE: permFault = hit && !selPerm[1];
      ACC_EXEC:  permFault = hit && !selPerm[2];
      default:   permFault = hit;
    endcase
  end

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IdxW   = $clog2(ENTRIES),
  localparam int AgeW   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               fillValid,
  input  logic               flush,
  input  logic               hit,
  input  logic [IdxW-1:0]    hitIdx,
  input  logic [ENTRIES-1:0] validVec,
  input  logic               fillMatch,
  input  logic [IdxW-1:0]    fillMatchIdx,
  output storeStrobe_t       strobe
);

  localparam logic [AgeW-1:0] OldestAge = AgeW'(ENTRIES - 1);

  logic [AgeW-1:0] ageArr [ENTRIES];
  logic [IdxW-1:0] freeIdx;
  logic            anyFree;
  logic [IdxW-1:0] victimIdx;
  logic [IdxW-1:0] wrIdx;
  logic            fillGo;
  logic            touchEn;
  logic [IdxW-1:0] touchIdx;
  logic [AgeW-1:0] touchAge;

  // Lowest-index empty slot: scan downward so that the lowest index is kept
  always_comb begin
    freeIdx = '0;
    anyFree = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!validVec[i]) begin
        freeIdx = IdxW'(i);
        anyFree = 1'b1;
      end
    end
  end

  // Ages always form a permutation, so exactly one entry holds the oldest age
  always_comb begin
    victimIdx = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ageArr[i] == OldestAge) victimIdx = IdxW'(i);
    end
  end

  always_comb begin
    if (fillMatch)    wrIdx = fillMatchIdx;
    else if (anyFree) wrIdx = freeIdx;
    else              wrIdx = victimIdx;
  end

  assign fillGo = fillValid && !flush;

  // A fill claims the recency update; otherwise a lookup hit does
  assign touchEn  = fillGo || hit;
  assign touchIdx = fillGo ? wrIdx : hitIdx;
  assign touchAge = ageArr[touchIdx];

  for (genvar i = 0; i < ENTRIES; i++) begin : gAge
    logic [AgeW-1:0] age;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        age <= AgeW'(i);
      end else if (touchEn) begin
        if (touchIdx == IdxW'(i)) age <= '0;
        else if (age < touchAge)  age <= age + 1'b1;
      end
    end
    assign ageArr[i] = age;
  end

  assign strobe.flushAll = flush;
  assign strobe.wrEn     = fillGo;
  assign strobe.wrIdx    = IDX_MAX'(wrIdx);

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lookupValid,
  input  logic [VPN_W-1:0] lookupVpn,
  input  logic [1:0]       lookupAcc,
  input  logic             fillValid,
  input  logic [VPN_W-1:0] fillVpn,
  input  logic [PPN_W-1:0] fillPpn,
  input  logic [2:0]       fillPerm,
  input  logic             flush,
  output logic             hit,
  output logic [PPN_W-1:0] hitPpn,
  output logic             permFault
);

  localparam int IdxW = $clog2(ENTRIES);

  storeStrobe_t       strobe;
  logic [IdxW-1:0]    hitIdx;
  logic [ENTRIES-1:0] validVec;
  logic               fillMatch;
  logic [IdxW-1:0]    fillMatchIdx;

  xlat_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .lookupValid(lookupValid), .lookupVpn(lookupVpn), .lookupAcc(lookupAcc),
    .fillVpn(fillVpn), .fillPpn(fillPpn), .fillPerm(fillPerm),
    .hit(hit), .hitPpn(hitPpn), .permFault(permFault),
    .hitIdx(hitIdx), .validVec(validVec),
    .fillMatch(fillMatch), .fillMatchIdx(fillMatchIdx)
  );

  xlat_ctrl #(.ENTRIES(ENTRIES)) uCtrl (
    .clk(clk), .rstN(rstN), .fillValid(fillValid), .flush(flush),
    .hit(hit), .hitIdx(hitIdx), .validVec(validVec),
    .fillMatch(fillMatch), .fillMatchIdx(fillMatchIdx),
    .strobe(strobe)
  );

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VPN_W = 20,
  parameter int PPN_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             lookupValid,
  input logic [VPN_W-1:0] lookupVpn,
  input logic             fillValid,
  input logic [VPN_W-1:0] fillVpn,
  input logic             flush,
  input logic             hit,
  input logic [PPN_W-1:0] hitPpn,
  input logic             permFault
);

  a_r1_idle_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |-> !hit);

  a_r2_miss_zero_ppn: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (hitPpn == '0));

  a_r3_fault_only_on_hit: assert property (@(posedge clk) disable iff (!rstN)
    permFault |-> hit);

  a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !hit);

  // R5/R4: an accepted fill is visible to a lookup of the same page next cycle
  a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rstN)
    ($past(fillValid) && !$past(flush) && lookupValid &&
     (lookupVpn == $past(fillVpn))) |-> hit);

endmodule

bind xlat_cache xlat_cache_chk #(.VPN_W(VPN_W), .PPN_W(PPN_W)) uChk (
  .clk(clk), .rstN(rstN), .lookupValid(lookupValid), .lookupVpn(lookupVpn),
  .fillValid(fillValid), .fillVpn(fillVpn), .flush(flush),
  .hit(hit), .hitPpn(hitPpn), .permFault(permFault)
);

// File: tb/sim_xlat_cache.sv
module sim_xlat_cache;

  localparam int N  = 8;
  localparam int VW = 20;
  localparam int PW = 20;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          lookupValid = 1'b0;
  logic [VW-1:0] lookupVpn = '0;
  logic [1:0]    lookupAcc = '0;
  logic          fillValid = 1'b0;
  logic [VW-1:0] fillVpn = '0;
  logic [PW-1:0] fillPpn = '0;
  logic [2:0]    fillPerm = '0;
  logic          flush = 1'b0;
  logic          hit;
  logic [PW-1:0] hitPpn;
  logic          permFault;

  always #2 clk = ~clk;  // 250 MHz

  xlat_cache #(.ENTRIES(N), .VPN_W(VW), .PPN_W(PW)) u0 (.*);

  // Scoreboard
  typedef struct {
    string         tag;
    logic          eHit;
    logic [PW-1:0] ePpn;
    logic          eFault;
  } expItem_t;

  expItem_t expQ[$];
  logic     sampleReq = 1'b0;
  int       nChecks = 0;
  int       nFails = 0;
  bit       finished = 1'b0;

  // Reference: slot contents plus a recency list (front = most recent)
  bit            mV    [N];
  logic [VW-1:0] mVpn  [N];
  logic [PW-1:0] mPpn  [N];
  logic [2:0]    mPerm [N];
  int            recent[$];

  function automatic int mFind(logic [VW-1:0] v);
    for (int i = 0; i < N; i++) if (mV[i] && mVpn[i] == v) return i;
    return -1;
  endfunction

  function automatic void mTouch(int idx);
    for (int i = 0; i < recent.size(); i++)
      if (recent[i] == idx) begin recent.delete(i); break; end
    recent.push_front(idx);
  endfunction

  function automatic void mFill(logic [VW-1:0] v, logic [PW-1:0] p, logic [2:0] pm);
    int idx;
    idx = mFind(v);
    if (idx < 0) for (int i = 0; i < N; i++) if (!mV[i]) begin idx = i; break; end
    if (idx < 0) idx = recent[recent.size() - 1];
    mV[idx] = 1'b1; mVpn[idx] = v; mPpn[idx] = p; mPerm[idx] = pm;
    mTouch(idx);
  endfunction

  function automatic expItem_t mExpect(string tag, logic [VW-1:0] v, logic [1:0] acc);
    expItem_t e;
    int idx;
    idx = mFind(v);
    e.tag    = tag;
    e.eHit   = (idx >= 0);
    e.ePpn   = (idx >= 0) ? mPpn[idx] : '0;
    e.eFault = (idx >= 0) && ((acc == 2'd3) || !mPerm[idx][acc]);
    return e;
  endfunction

  // Monitor: samples at the falling edge, between driver updates
  always @(negedge clk) begin
    if (sampleReq && !finished) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL scoreboard: sample with no expected item");
      end else begin
        expItem_t e;
        e = expQ.pop_front();
        nChecks++;
        if (hit !== e.eHit || hitPpn !== e.ePpn || permFault !== e.eFault) begin
          nFails++;
          $display("FAIL %s: hit/ppn/fault actual %0b/%h/%0b expected %0b/%h/%0b",
                   e.tag, hit, hitPpn, permFault, e.eHit, e.ePpn, e.eFault);
        end
      end
    end
  end

  // Driver tasks: entered just after a rising edge, leave just after the next
  task automatic endCycle();
    @(posedge clk); #1;
    lookupValid = 1'b0; fillValid = 1'b0; flush = 1'b0; sampleReq = 1'b0;
  endtask

  task automatic doLookup(string tag, logic [VW-1:0] v, logic [1:0] acc);
    int idx;
    expQ.push_back(mExpect(tag, v, acc));
    lookupValid = 1'b1; lookupVpn = v; lookupAcc = acc; sampleReq = 1'b1;
    endCycle();
    idx = mFind(v);
    if (idx >= 0) mTouch(idx);
  endtask

  task automatic idleLook(string tag, logic [VW-1:0] v);
    expItem_t e;
    e.tag = tag; e.eHit = 1'b0; e.ePpn = '0; e.eFault = 1'b0;
    expQ.push_back(e);
    lookupValid = 1'b0; lookupVpn = v; lookupAcc = 2'd0; sampleReq = 1'b1;
    endCycle();
  endtask

  task automatic doFill(logic [VW-1:0] v, logic [PW-1:0] p, logic [2:0] pm, bit withFlush);
    fillValid = 1'b1; fillVpn = v; fillPpn = p; fillPerm = pm; flush = withFlush;
    endCycle();
    if (withFlush) for (int i = 0; i < N; i++) mV[i] = 1'b0;
    else mFill(v, p, pm);
  endtask

  task automatic doFlush();
    flush = 1'b1;
    endCycle();
    for (int i = 0; i < N; i++) mV[i] = 1'b0;
  endtask

  task automatic lookFill(string tag, logic [VW-1:0] lv, logic [VW-1:0] fv, logic [PW-1:0] fp);
    expQ.push_back(mExpect(tag, lv, 2'd0));
    lookupValid = 1'b1; lookupVpn = lv; lookupAcc = 2'd0; sampleReq = 1'b1;
    fillValid = 1'b1; fillVpn = fv; fillPpn = fp; fillPerm = 3'b111;
    endCycle();
    mFill(fv, fp, 3'b111);  // the lookup's hit does not refresh recency
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete");
    finish();
  end

  initial begin
    for (int i = 0; i < N; i++) begin mV[i] = 1'b0; recent.push_back(i); end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;

    // R9: empty after reset
    doLookup("R9", 20'h00000, 2'd0);
    doLookup("R9", 20'h12345, 2'd0);

    // R4: distinct fills into an empty array, none lost
    for (int i = 0; i < N; i++) doFill(VW'(20'h10 + i), PW'(20'hA000 + i), 3'(i), 1'b0);
    for (int i = 0; i < N; i++) doLookup("R4", VW'(20'h10 + i), 2'd0);

    // R1: no hit when the request strobe is low
    idleLook("R1", 20'h11);
    doLookup("R1", 20'h17, 2'd2);

    // R2: physical page returned on hit, zero on miss
    doLookup("R2", 20'h15, 2'd2);
    doLookup("R2", 20'h99, 2'd1);

    // R3: permission bits against each access kind
    doLookup("R3", 20'h11, 2'd0);  // perm 001 read ok
    doLookup("R3", 20'h11, 2'd1);  // write forbidden
    doLookup("R3", 20'h11, 2'd2);  // exec forbidden
    doLookup("R3", 20'h16, 2'd0);  // perm 110 read forbidden
    doLookup("R3", 20'h16, 2'd1);
    doLookup("R3", 20'h17, 2'd3);  // reserved always faults
    doLookup("R3", 20'h55, 2'd1);  // miss never faults

    // R5: overwrite in place, nothing else lost
    doFill(20'h13, 20'hBEEF, 3'b100, 1'b0);
    doLookup("R5", 20'h13, 2'd2);
    for (int i = 0; i < N; i++) doLookup("R5", VW'(20'h10 + i), 2'd0);

    // R6: replacement of the least recently used entry, two orders
    doLookup("R6", 20'h14, 2'd0);
    doLookup("R6", 20'h10, 2'd0);
    doFill(20'h20, 20'hC020, 3'b111, 1'b0);
    for (int i = 0; i < N; i++) doLookup("R6", VW'(20'h10 + i), 2'd0);
    doLookup("R6", 20'h20, 2'd0);
    for (int i = N - 1; i >= 0; i--) doLookup("R6", VW'(20'h10 + i), 2'd0);
    doFill(20'h21, 20'hC021, 3'b111, 1'b0);
    doFill(20'h22, 20'hC022, 3'b111, 1'b0);
    for (int i = 0; i < N; i++) doLookup("R6", VW'(20'h10 + i), 2'd0);
    doLookup("R6", 20'h21, 2'd0);
    doLookup("R6", 20'h20, 2'd0);

    // R10: same-cycle lookup sees old contents; fill owns recency
    lookFill("R10", 20'h30, 20'h30, 20'hD030);
    doLookup("R10", 20'h30, 2'd0);
    lookFill("R10", 20'h12, 20'h31, 20'hD031);
    doFill(20'h32, 20'hD032, 3'b111, 1'b0);
    for (int i = 0; i < N; i++) doLookup("R10", VW'(20'h10 + i), 2'd0);

    // R7: flush empties everything
    doFlush();
    for (int i = 0; i < N; i++) doLookup("R7", VW'(20'h10 + i), 2'd0);
    doLookup("R7", 20'h30, 2'd0);

    // R8: fill dropped when flushed in the same cycle
    doFill(20'h40, 20'hE040, 3'b111, 1'b0);
    doFill(20'h41, 20'hE041, 3'b111, 1'b1);
    doLookup("R8", 20'h41, 2'd0);
    doLookup("R8", 20'h40, 2'd0);

    // R6: random traffic over a small page pool
    for (int k = 0; k < 1500; k++) begin
      int r;
      logic [VW-1:0] v;
      r = $urandom_range(0, 99);
      v = VW'($urandom_range(0, 15));
      if (r < 40)      doFill(v, PW'($urandom), 3'($urandom), 1'b0);
      else if (r < 42) doFlush();
      else if (r < 45) lookFill("R10", v, VW'($urandom_range(0, 15)), PW'($urandom));
      else             doLookup("R6", v, 2'($urandom));
    end

    repeat (2) @(posedge clk);
    if (expQ.size() != 0) begin
      nChecks++; nFails++;
      $display("FAIL scoreboard: %0d items never sampled, expected 0", expQ.size());
    end
    finish();
  end

endmodule